// File: doc/BRIEF.md
# Two-Wire Display Image Port

This block is the target side of an open-drain two-line serial bus. Its job is to move a 128-bit segment image between a bus controller and a display driver. The controller opens a transfer with a start condition and sends one address byte. The upper seven bits of that byte must equal a fixed nibble of 0111 followed by three strap pins. The lowest bit picks the direction of the transfer. After that come whole data bytes, each followed by a ninth acknowledge clock.

On a write, the block collects bits into a 128-bit shift register. It copies the register into the image output either when a full block of 128 bits has arrived (auto mode, enable input held high) or when the enable input pulses high while the clock is idle high (manual mode, enable held low). On a read, it drives the shift register out oldest bit first and wraps after 128 bits; the image output is left as it is.

Both bus lines are oversampled by the system clock through a synchronizer. The data line is driven only through an open-drain pull-low enable. That enable changes only while the bus clock is low, or is dropped when a start or stop is seen.

Top module: `lcd_i2c_port`

## Requirements
- R1: Out of reset the pull-low enable is deasserted and the image output is all zeros.
- R2: A start is a falling data line while the clock is high, and a stop is a rising data line while the clock is high. Clock pulses that are not preceded by a start get no acknowledge and have no effect.
- R3: After a start, the first eight bits are taken MSB first as an address byte. If its upper seven bits equal {0111, strap[2:0]}, the block pulls data low for the whole ninth clock. Bit 0 selects the direction: 0 for write, 1 for read.
- R4: On an address mismatch the line stays released for the ninth clock. All later clocks up to the next start are ignored: no acknowledge, and the image is unchanged.
- R5: In write mode, every eight received data bits are followed by a ninth clock during which the block pulls data low.
- R6: With the enable input high, the image output is loaded as soon as the 128th data bit after the address has been received, and not before. Data byte j (j = 0..15, MSB first on the bus) appears on image bits [127-8j : 120-8j].
- R7: With the enable input low, finishing a 128-bit block does not change the image. A high pulse on the enable input while the bus clock is high copies the shift register to the image.
- R8: In read mode, the shift register is sent oldest bit first, so a full 128-bit write reads back as the same byte sequence. The line is released during every ninth clock. A not-acknowledge (data high) from the controller on that clock ends the read.
- R9: Read-out wraps to the oldest bit after 128 bits and never changes the image output.
- R10: When a write continues past a 128-bit block with no stop or start, the first clock after that block's acknowledge clock is ignored, and reception resumes on the next clock.
- R11: A stop ends a transfer at any point. After it, clock pulses are ignored until a new start and a matching address arrive.
- R12: The pull-low enable only rises or falls while the bus clock is low, except that it is dropped after a start or stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen on the pin |
| sda_i | input | 1 | Bus data line as seen on the pin (wired value) |
| sda_oe_o | output | 1 | Pull-low enable for the data line; 1 drives low |
| strap_i | input | 3 | Address strap pins forming the low address bits |
| latch_en_i | input | 1 | Image latch enable: high for auto, low plus pulse for manual |
| disp_o | output | 128 | Latched display image |

## Verification
The hardest situation to reach from the ports is the ignored clock that follows a completed 128-bit block inside a transfer that keeps going. To reach it, the stimulus writes a full first image, clocks one extra pulse with the data line high, and then writes a second image in the same transfer. If the extra pulse were taken as data, every byte of the second image would come out shifted. A second corner is read wrap-around: the bench reads 32 bytes in one transfer and expects the written image twice, with the image output unchanged.

// File: rtl/lcdp_pkg.sv
package lcdp_pkg;

    typedef enum logic [2:0] {
        LK_IDLE,
        LK_ADDR,
        LK_AACK,
        LK_WDATA,
        LK_WACK,
        LK_SKIP,
        LK_RDATA,
        LK_RACK
    } link_st_e;

endpackage

// File: rtl/lcdp_cond.sv
module lcdp_cond #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic start_p,
    output logic stop_p,
    output logic rise_p,
    output logic fall_p
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] scl_sr;
        logic [SYNC_STAGES-1:0] sda_sr;
        logic                   scl_p;
        logic                   sda_p;
    } cond_t;

    cond_t cond_d, cond_q;

    // synchronized line levels (last stage of each chain)
    assign scl_lvl = cond_q.scl_sr[TOP];
    assign sda_lvl = cond_q.sda_sr[TOP];

    always_comb begin
        cond_d        = cond_q;
        cond_d.scl_sr = {cond_q.scl_sr[TOP-1:0], scl_raw};
        cond_d.sda_sr = {cond_q.sda_sr[TOP-1:0], sda_raw};
        cond_d.scl_p  = scl_lvl;
        cond_d.sda_p  = sda_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q <= '{scl_sr: '1, sda_sr: '1, scl_p: 1'b1, sda_p: 1'b1};
        end else begin
            cond_q <= cond_d;
        end
    end

    // bus events from two consecutive synchronized samples
    assign start_p = cond_q.scl_p & scl_lvl & cond_q.sda_p & ~sda_lvl;
    assign stop_p  = cond_q.scl_p & scl_lvl & ~cond_q.sda_p & sda_lvl;
    assign rise_p  = ~cond_q.scl_p & scl_lvl;
    assign fall_p  = cond_q.scl_p & ~scl_lvl;

endmodule

// File: rtl/lcdp_engine.sv
module lcdp_engine
    import lcdp_pkg::*;
#(
    parameter int          IMG_BITS  = 128,
    parameter int          ADDR_HI_W = 4,
    parameter logic [3:0]  ADDR_HI   = 4'b0111,
    parameter int          STRAP_W   = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_p,
    input  logic                stop_p,
    input  logic                rise_p,
    input  logic                fall_p,
    input  logic                sda_lvl,
    input  logic [STRAP_W-1:0]  strap,
    output logic                sda_oe,
    output logic [IMG_BITS-1:0] img,
    output logic                blk_done
);

    localparam int PTR_W  = $clog2(IMG_BITS);
    localparam int ADDR_W = ADDR_HI_W + STRAP_W;
    localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(IMG_BITS - 1);

    typedef struct packed {
        link_st_e            st;
        logic [2:0]          bitc;
        logic [ADDR_W:0]     adr;
        logic [IMG_BITS-1:0] img;
        logic [PTR_W-1:0]    wcnt;
        logic [PTR_W-1:0]    rptr;
        logic                full;
        logic                oe;
        logic                done;
    } eng_t;

    eng_t eng_d, eng_q;
    logic match;

    assign match = (eng_q.adr[ADDR_W:1] == {ADDR_HI[ADDR_HI_W-1:0], strap});

    always_comb begin
        eng_d      = eng_q;
        eng_d.done = 1'b0;
        if (start_p) begin
            eng_d.st   = LK_ADDR;
            eng_d.bitc = '0;
            eng_d.wcnt = '0;
            eng_d.full = 1'b0;
            eng_d.oe   = 1'b0;
        end else if (stop_p) begin
            eng_d.st = LK_IDLE;
            eng_d.oe = 1'b0;
        end else if (rise_p) begin
            case (eng_q.st)
                LK_ADDR: begin
                    eng_d.adr  = {eng_q.adr[ADDR_W-1:0], sda_lvl};
                    eng_d.bitc = eng_q.bitc + 3'd1;
                    if (eng_q.bitc == 3'd7) eng_d.st = LK_AACK;
                end
                LK_AACK: begin
                    eng_d.bitc = '0;
                    eng_d.rptr = LAST_IDX;
                    if (!match)           eng_d.st = LK_IDLE;
                    else if (eng_q.adr[0]) eng_d.st = LK_RDATA;
                    else                  eng_d.st = LK_WDATA;
                end
                LK_WDATA: begin
                    eng_d.img  = {eng_q.img[IMG_BITS-2:0], sda_lvl};
                    eng_d.bitc = eng_q.bitc + 3'd1;
                    if (eng_q.wcnt == LAST_IDX) begin
                        eng_d.wcnt = '0;
                        eng_d.full = 1'b1;
                        eng_d.done = 1'b1;
                    end else begin
                        eng_d.wcnt = eng_q.wcnt + 1'b1;
                    end
                    if (eng_q.bitc == 3'd7) eng_d.st = LK_WACK;
                end
                LK_WACK: begin
                    eng_d.bitc = '0;
                    eng_d.full = 1'b0;
                    eng_d.st   = eng_q.full ? LK_SKIP : LK_WDATA;
                end
                LK_SKIP: eng_d.st = LK_WDATA;
                LK_RDATA: begin
                    eng_d.rptr = (eng_q.rptr == '0) ? LAST_IDX : eng_q.rptr - 1'b1;
                    eng_d.bitc = eng_q.bitc + 3'd1;
                    if (eng_q.bitc == 3'd7) eng_d.st = LK_RACK;
                end
                LK_RACK: begin
                    eng_d.bitc = '0;
                    eng_d.st   = sda_lvl ? LK_IDLE : LK_RDATA;
                end
                default: ;
            endcase
        end else if (fall_p) begin
            case (eng_q.st)
                LK_AACK:  eng_d.oe = match;
                LK_WACK:  eng_d.oe = 1'b1;
                LK_RDATA: eng_d.oe = ~eng_q.img[eng_q.rptr];
                default:  eng_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= '{st: LK_IDLE, bitc: '0, adr: '0, img: '0, wcnt: '0,
                       rptr: '0, full: 1'b0, oe: 1'b0, done: 1'b0};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign sda_oe   = eng_q.oe;
    assign img      = eng_q.img;
    assign blk_done = eng_q.done;

endmodule

// File: rtl/lcdp_latch.sv
module lcdp_latch #(
    parameter int IMG_BITS    = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                en_raw,
    input  logic                scl_lvl,
    input  logic                blk_done,
    input  logic [IMG_BITS-1:0] img,
    output logic [IMG_BITS-1:0] disp
);

    localparam int TOP = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0] en_sr;
        logic                   en_p;
        logic [IMG_BITS-1:0]    disp;
    } lat_t;

    lat_t lat_d, lat_q;
    logic en_s;

    assign en_s = lat_q.en_sr[TOP];

    always_comb begin
        lat_d       = lat_q;
        lat_d.en_sr = {lat_q.en_sr[TOP-1:0], en_raw};
        lat_d.en_p  = en_s;
        if (blk_done && en_s) begin
            lat_d.disp = img;                       // auto load on full block
        end else if (en_s && !lat_q.en_p && scl_lvl) begin
            lat_d.disp = img;                       // manual strobe, clock idle
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lat_q <= '{en_sr: '0, en_p: 1'b0, disp: '0};
        end else begin
            lat_q <= lat_d;
        end
    end

    assign disp = lat_q.disp;

endmodule

// File: rtl/lcd_i2c_port.sv
module lcd_i2c_port #(
    parameter int         IMG_BITS    = 128,
    parameter int         SYNC_STAGES = 2,
    parameter int         STRAP_W     = 3,
    parameter int         ADDR_HI_W   = 4,
    parameter logic [3:0] ADDR_HI     = 4'b0111
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                scl_i,
    input  logic                sda_i,
    output logic                sda_oe_o,
    input  logic [STRAP_W-1:0]  strap_i,
    input  logic                latch_en_i,
    output logic [IMG_BITS-1:0] disp_o
);

    logic                scl_w, sda_w;
    logic                start_w, stop_w, rise_w, fall_w;
    logic                done_w;
    logic [IMG_BITS-1:0] img_w;

    lcdp_cond #(.SYNC_STAGES(SYNC_STAGES)) u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_raw (scl_i),
        .sda_raw (sda_i),
        .scl_lvl (scl_w),
        .sda_lvl (sda_w),
        .start_p (start_w),
        .stop_p  (stop_w),
        .rise_p  (rise_w),
        .fall_p  (fall_w)
    );

    lcdp_engine #(
        .IMG_BITS  (IMG_BITS),
        .ADDR_HI_W (ADDR_HI_W),
        .ADDR_HI   (ADDR_HI),
        .STRAP_W   (STRAP_W)
    ) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_p  (start_w),
        .stop_p   (stop_w),
        .rise_p   (rise_w),
        .fall_p   (fall_w),
        .sda_lvl  (sda_w),
        .strap    (strap_i),
        .sda_oe   (sda_oe_o),
        .img      (img_w),
        .blk_done (done_w)
    );

    lcdp_latch #(
        .IMG_BITS    (IMG_BITS),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_raw   (latch_en_i),
        .scl_lvl  (scl_w),
        .blk_done (done_w),
        .img      (img_w),
        .disp     (disp_o)
    );

endmodule

// File: rtl/lcdp_chk.sv
module lcdp_chk #(
    parameter int IMG_BITS = 128
) (
    input logic                clk,
    input logic                rst_n,
    input logic                scl_i,
    input logic                latch_en_i,
    input logic                sda_oe_o,
    input logic                start_w,
    input logic                stop_w,
    input logic [IMG_BITS-1:0] disp_o
);

    // R12: pull-low only starts while the bus clock is low
    p_oe_rise_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe_o) |-> !scl_i);

    // R12: release outside start/stop handling also only while clock low
    p_oe_fall_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe_o) && !$past(start_w) && !$past(stop_w)) |-> !scl_i);

    // R11: a stop drops the drive on the next cycle
    p_stop_release_r11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_w |=> !sda_oe_o);

    // R2: a start drops the drive on the next cycle
    p_start_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_w |=> !sda_oe_o);

    // R7: the image changes only while the enable input is high
    p_disp_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(disp_o) |-> $past(latch_en_i));

endmodule

bind lcd_i2c_port lcdp_chk #(.IMG_BITS(IMG_BITS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .latch_en_i (latch_en_i),
    .sda_oe_o   (sda_oe_o),
    .start_w    (start_w),
    .stop_w     (stop_w),
    .disp_o     (disp_o)
);

// File: tb/tb_lcd_i2c_port.sv
`timescale 1ns/1ps
module tb_lcd_i2c_port;

    localparam int Q = 6;   // system clocks per bus half phase

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         scl_m = 1'b1;
    logic         sda_m = 1'b1;
    logic [2:0]   strap = 3'b101;
    logic         en = 1'b1;
    logic         sda_oe;
    logic [127:0] disp;
    wire          sda_line = sda_m & ~sda_oe;

    int  checks = 0;
    int  errors = 0;
    bit  glitch = 1'b0;
    bit  done = 1'b0;

    always #2 clk = ~clk;

    lcd_i2c_port dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_m),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .strap_i    (strap),
        .latch_en_i (en),
        .disp_o     (disp)
    );

    task automatic chk(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [127:0] mk_img(input logic [7:0] seed);
        logic [127:0] v;
        for (int j = 0; j < 16; j++) v[127-8*j -: 8] = seed + 8'(j * 29);
        return v;
    endfunction

    // one bus clock: drive b, return the line and the drive during the high phase
    task automatic clk_bit(input logic b, output logic r, output logic oeh);
        logic oe0;
        sda_m = b;
        wait_n(Q);
        scl_m = 1'b1;
        wait_n(1);
        oe0 = sda_oe;
        for (int i = 0; i < Q; i++) begin
            @(negedge clk);
            if (sda_oe !== oe0) glitch = 1'b1;
        end
        r   = sda_line;
        oeh = sda_oe;
        scl_m = 1'b0;
        wait_n(3);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; scl_m = 1'b1; wait_n(Q);
        sda_m = 1'b0; wait_n(Q);
        scl_m = 1'b0; wait_n(3);
    endtask

    task automatic bus_stop();
        scl_m = 1'b0; wait_n(3);
        sda_m = 1'b0; wait_n(Q);
        scl_m = 1'b1; wait_n(Q);
        sda_m = 1'b1; wait_n(Q);
    endtask

    task automatic send_byte(input logic [7:0] v, output logic ack);
        logic r, o;
        for (int m = 7; m >= 0; m--) clk_bit(v[m], r, o);
        clk_bit(1'b1, r, o);
        ack = ~r;
    endtask

    task automatic recv_byte(input logic last, output logic [7:0] v, output logic rel);
        logic r, o;
        for (int m = 7; m >= 0; m--) begin
            clk_bit(1'b1, r, o);
            v[m] = r;
        end
        clk_bit(last, r, o);
        rel = ~o;
    endtask

    task automatic write_bytes(input logic [127:0] img, input int from, input int to,
                               output int nacks);
        logic a;
        nacks = 0;
        for (int j = from; j <= to; j++) begin
            send_byte(img[127-8*j -: 8], a);
            if (!a) nacks++;
        end
    endtask

    // ---------------- scenarios ----------------
    task automatic t_reset();
        chk(sda_oe === 1'b0, "R1 drive released after reset", 128'(sda_oe), 128'd0);
        chk(disp === '0, "R1 image zero after reset", disp, '0);
    endtask

    task automatic t_no_start();
        logic a;
        scl_m = 1'b0; wait_n(3);
        send_byte({4'b0111, strap, 1'b0}, a);
        chk(a == 1'b0, "R2 no ack without start", 128'(a), 128'd0);
        bus_stop();
    endtask

    task automatic t_mismatch();
        logic a;
        bus_start();
        send_byte({4'b0111, 3'b100, 1'b0}, a);
        chk(a == 1'b0, "R4 mismatched address not acknowledged", 128'(a), 128'd0);
        send_byte(8'hA5, a);
        chk(a == 1'b0, "R4 data after mismatch ignored", 128'(a), 128'd0);
        bus_stop();
        chk(disp === '0, "R4 image unchanged", disp, '0);
    endtask

    task automatic t_auto(input logic [127:0] img);
        logic a; int n;
        en = 1'b1;
        bus_start();
        send_byte({4'b0111, strap, 1'b0}, a);
        chk(a == 1'b1, "R3 matching address acknowledged", 128'(a), 128'd1);
        write_bytes(img, 0, 7, n);
        chk(disp === '0, "R6 no load before 128 bits", disp, '0);
        write_bytes(img, 8, 15, n);
        chk(n == 0, "R5 every data byte acknowledged", 128'(n), 128'd0);
        chk(disp === img, "R6 auto load after 128 bits", disp, img);
        bus_stop();
    endtask

    task automatic t_skip(input logic [127:0] i1, input logic [127:0] i2);
        logic a, r, o; int n;
        bus_start();
        send_byte({4'b0111, strap, 1'b0}, a);
        write_bytes(i1, 0, 15, n);
        clk_bit(1'b1, r, o);
        chk(o == 1'b0, "R10 ignored clock not driven", 128'(o), 128'd0);
        write_bytes(i2, 0, 15, n);
        chk(n == 0, "R10 bytes after ignored clock acknowledged", 128'(n), 128'd0);
        chk(disp === i2, "R10 second block aligned", disp, i2);
        bus_stop();
    endtask

    task automatic t_manual(input logic [127:0] prev, input logic [127:0] img);
        logic a; int n;
        en = 1'b0;
        wait_n(Q);
        bus_start();
        send_byte({4'b0111, strap, 1'b0}, a);
        write_bytes(img, 0, 15, n);
        bus_stop();
        chk(disp === prev, "R7 no auto load with enable low", disp, prev);
        en = 1'b1; wait_n(10);
        en = 1'b0; wait_n(10);
        chk(disp === img, "R7 enable pulse loads image", disp, img);
    endtask

    task automatic t_read(input logic [127:0] img);
        logic a, rel; logic [7:0] v; logic [127:0] got1, got2; int rel_bad;
        rel_bad = 0;
        bus_start();
        send_byte({4'b0111, strap, 1'b1}, a);
        chk(a == 1'b1, "R3 read address acknowledged", 128'(a), 128'd1);
        for (int j = 0; j < 16; j++) begin
            recv_byte(1'b0, v, rel);
            got1[127-8*j -: 8] = v;
            if (!rel) rel_bad++;
        end
        for (int j = 0; j < 16; j++) begin
            recv_byte(j == 15, v, rel);
            got2[127-8*j -: 8] = v;
            if (!rel) rel_bad++;
        end
        chk(got1 === img, "R8 read returns oldest bit first", got1, img);
        chk(rel_bad == 0, "R8 line released on ninth clock", 128'(rel_bad), 128'd0);
        chk(got2 === img, "R9 read wraps after 128 bits", got2, img);
        bus_stop();
        chk(disp === img, "R9 read leaves image unchanged", disp, img);
    endtask

    task automatic t_stop(input logic [127:0] prev, input logic [127:0] img);
        logic a; int n;
        en = 1'b1;
        bus_start();
        send_byte({4'b0111, strap, 1'b0}, a);
        write_bytes(img, 0, 2, n);
        bus_stop();
        chk(disp === prev, "R11 partial transfer not loaded", disp, prev);
        scl_m = 1'b0; wait_n(3);
        send_byte({4'b0111, strap, 1'b0}, a);
        chk(a == 1'b0, "R11 clocks after stop ignored", 128'(a), 128'd0);
        bus_stop();
        bus_start();
        send_byte({4'b0111, strap, 1'b0}, a);
        chk(a == 1'b1, "R11 new start and address accepted", 128'(a), 128'd1);
        write_bytes(img, 0, 15, n);
        bus_stop();
        chk(disp === img, "R11 resumed transfer loaded", disp, img);
    endtask

    initial begin
        logic [127:0] ia, ib, ic, id, ie;
        ia = mk_img(8'h13); ib = mk_img(8'h5C); ic = mk_img(8'hA1);
        id = mk_img(8'h2E); ie = mk_img(8'hF7);
        wait_n(5);
        rst_n = 1'b1;
        wait_n(5);
        t_reset();
        t_no_start();
        t_mismatch();
        t_auto(ia);
        t_skip(ib, ic);
        t_manual(ic, id);
        t_read(id);
        t_stop(id, ie);
        chk(glitch == 1'b0, "R12 drive steady while clock high", 128'(glitch), 128'd0);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 150000; i++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule